// File: doc/BRIEF.md
# Configuration-Space Target Responder

This block answers configuration-space transactions on a multiplexed 32-bit address/data bus of the conventional parallel peripheral kind. During the address phase it checks three things: the per-slot configuration select line, the command nibble on the command/byte-enable lines, and the low address bits. When all of them qualify, it claims the transaction by driving device select. It then completes exactly one data word against a small internal register file and releases the bus.

Reads always return the whole 32-bit register, whatever the byte enables say. Writes update only the bytes whose active-low enable is asserted. If the initiator tries to keep the transaction going past the first word, the target signals a disconnect together with the one word it accepts. Register slots beyond the implemented count are decoded and claimed, but they read as zero and drop writes. The handshake timing is the same as for an ordinary single-word target transaction. A parameter can add decode wait states before target ready.

Top module: `cfgt_target`

## Requirements
- R1: A transaction is claimed only if, in its address phase (the first cycle with `frame_n` low after a cycle with it high), `idsel` is high, `cbe_n` carries 4'b1010 (read) or 4'b1011 (write), and `ad_in[1:0]` is 2'b00. Otherwise `devsel_n` stays high.
- R2: With the default of zero wait states, `devsel_n` goes low in the first cycle after the address phase, with `trdy_n` still high. `trdy_n` goes low in the second cycle after the address phase. `trdy_n` is never low while `devsel_n` is high.
- R3: A read drives the full 32-bit register onto `ad_out` with `ad_oe` high while `trdy_n` is low, whatever the byte enables are. `ad_oe` stays low in the turnaround cycle where only `devsel_n` is asserted.
- R4: A write commits at the clock edge where `irdy_n` and `trdy_n` are both low. Byte k (bits 8k+7:8k) is updated only if `cbe_n[k]` is 0 in that cycle. All other bytes keep their value.
- R5: Only one data word moves per transaction. In the cycle after the transfer edge, `devsel_n` and `trdy_n` are both high.
- R6: If `frame_n` is still low in the data phase, `stop_n` is driven low together with `trdy_n`, so the transaction disconnects after one word. `stop_n` stays high in a single-word transaction.
- R7: Register indices at or above `NUM_REGS` (16 by default) are claimed, read as zero, and ignore writes.
- R8: After reset, all registers hold zero, `devsel_n`, `trdy_n` and `stop_n` are high, and `ad_oe` is low.
- R9: The register index is `ad_in[7:2]` of the address phase. Address bits above bit 7 do not affect which register is selected.
- R10: While `irdy_n` is high in the data phase, the target keeps `trdy_n` low and holds the read data steady until the transfer edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_n | input | 1 | Initiator transaction frame, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| idsel | input | 1 | Configuration select for this slot, active high |
| cbe_n | input | 4 | Command in the address phase, active-low byte enables in the data phase |
| ad_in | input | 32 | Address/data bus as seen by the target |
| ad_out | output | 32 | Read data driven onto the bus |
| ad_oe | output | 1 | Output enable for `ad_out` |
| devsel_n | output | 1 | Device select, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Disconnect request, active low |

## Verification
Take the clock edge that samples the address phase as edge 0. Device select is due in the cycle after edge 0, and target ready and read data in the cycle after that. The write result appears only after the edge at which initiator and target ready are both low. Release of device select is due in the cycle after that edge. The bench sets its inputs on falling edges and samples the outputs shortly after each one. It records the cycle number at which each handshake output first changes and compares that number with the expected one, so a result that arrives one cycle early or late counts as a failure. Stored values are checked by a later read transaction, never by looking inside the design.

// File: rtl/cfgt_pkg.sv
package cfgt_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_DSEL = 2'd1,
      ST_DATA = 2'd2,
      ST_DONE = 2'd3
   } cfgt_state_e;

   localparam logic [3:0] CMD_CFG_RD = 4'b1010;
   localparam logic [3:0] CMD_CFG_WR = 4'b1011;
   localparam int         CMD_W      = 4;
   localparam int         IDX_LSB    = 2;

endpackage

// File: rtl/cfgt_addr_decode.sv
module cfgt_addr_decode
   import cfgt_pkg::*;
#(
   parameter int IDX_W = 6
) (
   input  logic                   idsel,
   input  logic [CMD_W-1:0]       cmd_n,
   input  logic [IDX_W+IDX_LSB-1:0] addr_lo,
   output logic                   hit,
   output logic                   is_write,
   output logic [IDX_W-1:0]       index
);

   localparam int ADDR_LO_W = IDX_W + IDX_LSB;

   generate
      if (IDX_W < 1 || ADDR_LO_W > 32) begin : g_bad_idx
         $error("cfgt_addr_decode: IDX_W out of range");
      end
   endgenerate

   logic cmd_rd;
   logic cmd_wr;
   logic aligned;

   always_comb begin
      cmd_rd   = (cmd_n == CMD_CFG_RD);
      cmd_wr   = (cmd_n == CMD_CFG_WR);
      aligned  = (addr_lo[IDX_LSB-1:0] == '0);
      hit      = idsel && (cmd_rd || cmd_wr) && aligned;
      is_write = cmd_wr;
      index    = addr_lo[ADDR_LO_W-1:IDX_LSB];
   end

endmodule

// File: rtl/cfgt_fsm.sv
module cfgt_fsm
   import cfgt_pkg::*;
#(
   parameter int WAIT_STATES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_n,
   input  logic irdy_n,
   input  logic hit,
   output logic addr_take,
   output logic xfer,
   output logic in_data,
   output logic devsel_n,
   output logic trdy_n,
   output logic stop_n
);

   generate
      if (WAIT_STATES < 0 || WAIT_STATES > 15) begin : g_bad_wait
         $error("cfgt_fsm: WAIT_STATES must be 0..15");
      end
   endgenerate

   cfgt_state_e state;
   logic        frame_q;
   logic        wait_done;

   // address phase: frame newly asserted while idle
   assign addr_take = (state == ST_IDLE) && !frame_n && frame_q && hit;
   assign in_data   = (state == ST_DATA);
   assign xfer      = in_data && !irdy_n;
   assign devsel_n  = !((state == ST_DSEL) || (state == ST_DATA));
   assign trdy_n    = !in_data;
   assign stop_n    = !(in_data && !frame_n);

   generate
      if (WAIT_STATES == 0) begin : g_nowait
         assign wait_done = 1'b1;
      end else begin : g_wait
         localparam int CNT_W = $clog2(WAIT_STATES + 1);
         logic [CNT_W-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (state == ST_DSEL && !wait_done) begin
               cnt <= cnt + 1'b1;
            end else begin
               cnt <= '0;
            end
         end
         assign wait_done = (cnt == CNT_W'(WAIT_STATES));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         frame_q <= 1'b1;
      end else begin
         frame_q <= frame_n;
         unique case (state)
            ST_IDLE: if (addr_take) state <= ST_DSEL;
            ST_DSEL: if (wait_done) state <= ST_DATA;
            ST_DATA: if (!irdy_n)   state <= ST_DONE;
            ST_DONE: if (frame_n)   state <= ST_IDLE;
            default:                state <= ST_IDLE;
         endcase
      end
   end

   AST_TRDY_NEEDS_DEVSEL: assert property (@(posedge clk) disable iff (!rst_n) !trdy_n |-> !devsel_n); // R2
   AST_SINGLE_PHASE: assert property (@(posedge clk) disable iff (!rst_n) (!trdy_n && !irdy_n) |=> (trdy_n && devsel_n)); // R5
   AST_STOP_WITH_TRDY: assert property (@(posedge clk) disable iff (!rst_n) !stop_n |-> !trdy_n); // R6
   AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!trdy_n && irdy_n) |=> !trdy_n); // R10

endmodule

// File: rtl/cfgt_regfile.sv
module cfgt_regfile #(
   parameter int DATA_W   = 32,
   parameter int IDX_W    = 6,
   parameter int NUM_REGS = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [IDX_W-1:0]    wr_idx,
   input  logic [DATA_W/8-1:0] wr_be,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic [IDX_W-1:0]    rd_idx,
   output logic [DATA_W-1:0]   rd_data
);

   localparam int BYTES = DATA_W / 8;

   generate
      if (DATA_W % 8 != 0 || DATA_W < 32) begin : g_bad_width
         $error("cfgt_regfile: DATA_W must be a multiple of 8, at least 32");
      end
      if (NUM_REGS < 1 || NUM_REGS > (1 << IDX_W)) begin : g_bad_depth
         $error("cfgt_regfile: NUM_REGS must fit the index space");
      end
   endgenerate

   logic [DATA_W-1:0] regs [NUM_REGS];

   generate
      for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
         logic [DATA_W-1:0] q;
         logic              sel;
         assign sel     = wr_en && (int'(wr_idx) == r);
         assign regs[r] = q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q <= '0;
            end else if (sel) begin
               for (int b = 0; b < BYTES; b++) begin
                  if (wr_be[b]) q[b*8 +: 8] <= wr_data[b*8 +: 8];
               end
            end
         end
         for (genvar b = 0; b < BYTES; b++) begin : g_byte
            AST_BYTE_KEEP: assert property (@(posedge clk) disable iff (!rst_n) (sel && !wr_be[b]) |=> $stable(q[b*8 +: 8])); // R4
         end
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (int'(rd_idx) == i) rd_data = regs[i];
      end
   end

   AST_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (int'(rd_idx) >= NUM_REGS) |-> (rd_data == '0)); // R7

endmodule

// File: rtl/cfgt_target.sv
module cfgt_target
   import cfgt_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int IDX_W       = 6,
   parameter int NUM_REGS    = 16,
   parameter int WAIT_STATES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_n,
   input  logic              irdy_n,
   input  logic              idsel,
   input  logic [DATA_W/8-1:0] cbe_n,
   input  logic [DATA_W-1:0] ad_in,
   output logic [DATA_W-1:0] ad_out,
   output logic              ad_oe,
   output logic              devsel_n,
   output logic              trdy_n,
   output logic              stop_n
);

   localparam int BYTES = DATA_W / 8;

   generate
      if (BYTES < CMD_W) begin : g_bad_bus
         $error("cfgt_target: bus too narrow for the command nibble");
      end
   endgenerate

   logic             hit;
   logic             dec_wr;
   logic [IDX_W-1:0] dec_idx;
   logic             addr_take;
   logic             xfer;
   logic             in_data;
   logic             wr_q;
   logic [IDX_W-1:0] idx_q;

   cfgt_addr_decode #(.IDX_W(IDX_W)) u_dec (
      .idsel    (idsel),
      .cmd_n    (cbe_n[CMD_W-1:0]),
      .addr_lo  (ad_in[IDX_W+IDX_LSB-1:0]),
      .hit      (hit),
      .is_write (dec_wr),
      .index    (dec_idx)
   );

   cfgt_fsm #(.WAIT_STATES(WAIT_STATES)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_n   (frame_n),
      .irdy_n    (irdy_n),
      .hit       (hit),
      .addr_take (addr_take),
      .xfer      (xfer),
      .in_data   (in_data),
      .devsel_n  (devsel_n),
      .trdy_n    (trdy_n),
      .stop_n    (stop_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q  <= 1'b0;
         idx_q <= '0;
      end else if (addr_take) begin
         wr_q  <= dec_wr;
         idx_q <= dec_idx;
      end
   end

   cfgt_regfile #(
      .DATA_W   (DATA_W),
      .IDX_W    (IDX_W),
      .NUM_REGS (NUM_REGS)
   ) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (xfer && wr_q),
      .wr_idx  (idx_q),
      .wr_be   (~cbe_n),
      .wr_data (ad_in),
      .rd_idx  (idx_q),
      .rd_data (ad_out)
   );

   assign ad_oe = in_data && !wr_q;

   AST_CLAIM_IDSEL: assert property (@(posedge clk) disable iff (!rst_n) $fell(devsel_n) |-> $past(idsel)); // R1
   AST_OE_WITH_TRDY: assert property (@(posedge clk) disable iff (!rst_n) ad_oe |-> (!trdy_n && !devsel_n)); // R3
   AST_READ_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (ad_oe && irdy_n) |=> $stable(ad_out)); // R10

endmodule

// File: tb/cfgt_target_bench.sv
module cfgt_target_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_n = 1'b1;
   logic        irdy_n = 1'b1;
   logic        idsel = 1'b0;
   logic [3:0]  cbe_n = 4'hF;
   logic [31:0] ad_in = '0;
   logic [31:0] ad_out;
   logic        ad_oe;
   logic        devsel_n;
   logic        trdy_n;
   logic        stop_n;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   always #5 clk = ~clk;

   cfgt_target u_cfgt_target (
      .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
      .idsel(idsel), .cbe_n(cbe_n), .ad_in(ad_in), .ad_out(ad_out),
      .ad_oe(ad_oe), .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 20000) begin
         fails = fails + 1;
         checks = checks + 1;
         $display("FAIL R5 watchdog actual=%0d expected<%0d", cyc, 20000);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks = checks + 1;
      if (!ok) begin
         fails = fails + 1;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // transaction results
   int          t_dev, t_trdy, t_xfer;
   logic [31:0] rdata;
   bit          stop_seen, oe_c1, oe_x, released, wait_stable;

   task automatic txn(input bit sel, input logic [3:0] cmd, input logic [31:0] addr,
                      input logic [3:0] be, input logic [31:0] wdata,
                      input bit burst, input int delay);
      logic [31:0] first;
      bit fin = 0;
      t_dev = 0; t_trdy = 0; t_xfer = 0; rdata = '0;
      stop_seen = 0; oe_c1 = 0; oe_x = 0; released = 0; wait_stable = 1;
      first = '0;
      @(negedge clk);
      frame_n = 1'b0; idsel = sel; cbe_n = cmd; ad_in = addr; irdy_n = 1'b1;
      @(posedge clk);
      for (int c = 1; c <= 12 && !fin; c++) begin
         @(negedge clk);
         idsel = 1'b0;
         cbe_n = be;
         ad_in = cmd[0] ? wdata : 32'h0;
         irdy_n = (c > delay) ? 1'b0 : 1'b1;
         if (!burst && !irdy_n) frame_n = 1'b1;
         #1;
         if (c == 1) oe_c1 = ad_oe;
         if (!devsel_n && t_dev == 0) t_dev = c;
         if (!trdy_n && t_trdy == 0) begin
            t_trdy = c;
            first = ad_out;
         end
         if (!trdy_n && irdy_n && ad_out != first) wait_stable = 0;
         if (!trdy_n && !irdy_n) begin
            t_xfer = c; rdata = ad_out; stop_seen = !stop_n; oe_x = ad_oe;
            @(negedge clk);
            frame_n = 1'b1; irdy_n = 1'b1;
            #1;
            released = devsel_n && trdy_n;
            fin = 1;
         end else if (c == 6 && devsel_n) begin
            @(negedge clk);
            frame_n = 1'b1; irdy_n = 1'b1;
            fin = 1;
         end
      end
      @(negedge clk);
      frame_n = 1'b1; irdy_n = 1'b1;
   endtask

   typedef struct packed {
      logic        sel;
      logic [3:0]  cmd;
      logic [31:0] addr;
      logic [3:0]  be;
      logic [31:0] data;
      logic        claim;
      logic [31:0] exp;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 4'hB, 32'h0000_0004, 4'h0, 32'h1122_3344, 1'b1, 32'h0, 4'd4},          // R4 full write idx1
      '{1'b1, 4'hA, 32'h0000_0004, 4'h0, 32'h0, 1'b1, 32'h1122_3344, 4'd3},          // R3 read back
      '{1'b1, 4'hB, 32'h0000_0004, 4'hA, 32'hAABB_CCDD, 1'b1, 32'h0, 4'd4},          // R4 bytes 0,2
      '{1'b1, 4'hA, 32'h0000_0004, 4'hF, 32'h0, 1'b1, 32'h11BB_33DD, 4'd3},          // R3 enables ignored
      '{1'b1, 4'hB, 32'h0000_003C, 4'h0, 32'hCAFE_F00D, 1'b1, 32'h0, 4'd4},          // R4 last register
      '{1'b1, 4'hA, 32'h0000_003C, 4'h0, 32'h0, 1'b1, 32'hCAFE_F00D, 4'd3},
      '{1'b1, 4'hB, 32'h0000_0040, 4'h0, 32'hFFFF_FFFF, 1'b1, 32'h0, 4'd7},          // R7 write ignored
      '{1'b1, 4'hA, 32'h0000_0040, 4'h0, 32'h0, 1'b1, 32'h0, 4'd7},                  // R7 reads zero
      '{1'b0, 4'hB, 32'h0000_0008, 4'h0, 32'h1234_5678, 1'b0, 32'h0, 4'd1},          // R1 no idsel
      '{1'b1, 4'hA, 32'h0000_0008, 4'h0, 32'h0, 1'b1, 32'h0, 4'd1},
      '{1'b1, 4'h7, 32'h0000_0008, 4'h0, 32'h1234_5678, 1'b0, 32'h0, 4'd1},          // R1 wrong command
      '{1'b1, 4'hA, 32'h0000_0008, 4'h0, 32'h0, 1'b1, 32'h0, 4'd1},
      '{1'b1, 4'hB, 32'h0000_0009, 4'h0, 32'h1234_5678, 1'b0, 32'h0, 4'd1},          // R1 misaligned
      '{1'b1, 4'hA, 32'h0000_0008, 4'h0, 32'h0, 1'b1, 32'h0, 4'd1},
      '{1'b1, 4'hB, 32'h0000_0108, 4'h0, 32'h5A5A_5A5A, 1'b1, 32'h0, 4'd9},          // R9 high bits ignored
      '{1'b1, 4'hA, 32'h0000_0008, 4'h0, 32'h0, 1'b1, 32'h5A5A_5A5A, 4'd9}
   };

   initial begin
      string rq;
      #23;
      // R8 reset state
      chk(devsel_n && trdy_n && stop_n && !ad_oe, "R8 reset outputs",
          {28'h0, devsel_n, trdy_n, stop_n, ad_oe}, 32'h0000_000E);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      txn(1'b1, 4'hA, 32'h0, 4'h0, 32'h0, 1'b0, 0);
      chk(rdata == 32'h0, "R8 register zero after reset", rdata, 32'h0);

      for (int i = 0; i < NV; i++) begin
         rq = $sformatf("R%0d vector %0d", VECS[i].req, i);
         txn(VECS[i].sel, VECS[i].cmd, VECS[i].addr, VECS[i].be, VECS[i].data, 1'b0, 0);
         chk((t_dev != 0) == VECS[i].claim, {rq, " claim"}, t_dev, VECS[i].claim);
         if (VECS[i].claim && !VECS[i].cmd[0])
            chk(rdata == VECS[i].exp, {rq, " data"}, rdata, VECS[i].exp);
      end

      // R2 handshake timing, R3 turnaround, R5 release, R6 no stop when single
      txn(1'b1, 4'hB, 32'h10, 4'h0, 32'h0BAD_F00D, 1'b0, 0);
      chk(t_dev == 1, "R2 devsel cycle", t_dev, 1);
      chk(t_trdy == 2, "R2 trdy cycle", t_trdy, 2);
      chk(released, "R5 release after write", released, 1);
      txn(1'b1, 4'hA, 32'h10, 4'h0, 32'h0, 1'b0, 0);
      chk(!oe_c1 && oe_x, "R3 oe off in turnaround, on with trdy", {oe_c1, oe_x}, 2'b01);
      chk(rdata == 32'h0BAD_F00D, "R3 read data", rdata, 32'h0BAD_F00D);
      chk(!stop_seen, "R6 no stop on single word", stop_seen, 0);
      chk(released, "R5 release after read", released, 1);

      // R6 burst attempt disconnects after one word
      txn(1'b1, 4'hB, 32'h0C, 4'h0, 32'h0102_0304, 1'b1, 0);
      chk(stop_seen, "R6 stop with first word", stop_seen, 1);
      chk(released, "R5 release after burst write", released, 1);
      txn(1'b1, 4'hA, 32'h0C, 4'h0, 32'h0, 1'b1, 0);
      chk(stop_seen && rdata == 32'h0102_0304, "R6 burst read one word", rdata, 32'h0102_0304);

      // R10 initiator wait states
      txn(1'b1, 4'hA, 32'h04, 4'h0, 32'h0, 1'b0, 3);
      chk(t_trdy == 2 && t_xfer == 4, "R10 transfer cycle", t_xfer, 4);
      chk(wait_stable && rdata == 32'h11BB_33DD, "R10 data held", rdata, 32'h11BB_33DD);
      txn(1'b1, 4'hB, 32'h14, 4'hC, 32'h7777_8888, 1'b0, 2);
      txn(1'b1, 4'hA, 32'h14, 4'h0, 32'h0, 1'b0, 0);
      chk(rdata == 32'h0000_8888, "R4 delayed partial write", rdata, 32'h0000_8888);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule